// File: doc/BRIEF.md
# Duplicated-Wire Parity Link Codec

This block guards a narrow on-chip link against coupling noise and single bit upsets. On the sending side each data bit is driven onto a pair of neighbouring wires. Because both wires of a pair always switch in the same direction, no wire ever sees both of its neighbours switching against it. One more wire carries the XOR of all data bits. On the receiving side, parity is recomputed over one of the two copies and compared with the received parity wire. If they agree, that copy is taken. If they differ, the other copy is taken. A single flipped wire anywhere in the codeword, including the parity wire, is therefore corrected.

The encoder and decoder are combinational. A thin registered wrapper puts a flop stage after each of them so the pair can be tested and timed as one unit. The encode path registers on every cycle. The decode path registers only when the receive enable is high and otherwise holds its last result. The data width is a parameter, and the codeword is twice that width plus one.

Top module: `dup_parity_codec`

## Requirements
- R1: The codeword is 2*DW+1 bits wide. For every data bit i, codeword bits 2i and 2i+1 both carry data bit i. Bit 2i+1 is the upper wire of the pair, so pairs run from the data MSB down to the LSB.
- R2: Codeword bit 2*DW, the most significant bit, is the XOR of all data bits.
- R3: tx_code takes the encoding of tx_data at the next rising clock edge and holds it until the following edge.
- R4: A codeword with no error, presented with rx_en high, yields the original data on rx_data.
- R5: A codeword with exactly one data wire inverted (any of bits 0 to 2*DW-1) still yields the original data.
- R6: A codeword whose parity wire (bit 2*DW) is inverted still yields the original data.
- R7: While rx_en is low, rx_data keeps its value whatever rx_code carries.
- R8: While rst_n is low, tx_code and rx_data are all zeros.
- R9: With rx_en high, rx_data shows the decode of rx_code one clock edge after rx_code is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DW | Data word to encode |
| tx_code | output | 2*DW+1 | Registered codeword for the link |
| rx_code | input | 2*DW+1 | Codeword received from the link |
| rx_en | input | 1 | Decoder enable; loads rx_data when high |
| rx_data | output | DW | Registered corrected data |

## Verification
The bench builds the block with its default width of four data bits. At that width the space is small enough to sweep completely: every one of the 16 data words is paired with every one of the nine single-wire faults and with the fault-free case. This covers each data-wire position, the parity wire and the clean path. Hold behaviour under a low enable and the one-cycle latency of both paths are checked against the same behavioural model.

// File: rtl/dap_pkg.sv
package dap_pkg;
  // codeword width for a given data width: two wires per bit plus parity
  function automatic int unsigned code_width(input int unsigned dw);
    return 2 * dw + 1;
  endfunction
endpackage

// File: rtl/dap_parity_tree.sv
module dap_parity_tree #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] bits_i,
  output logic         par_o
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned PAD = 1 << LVL;

  logic [2*PAD-2:0] node;

  // leaves: inputs then zero padding
  generate
    for (genvar l = 0; l < PAD; l++) begin : g_leaf
      if (l < N) begin : g_in
        assign node[PAD-1+l] = bits_i[l];
      end else begin : g_pad
        assign node[PAD-1+l] = 1'b0;
      end
    end
    for (genvar k = 0; k < PAD-1; k++) begin : g_node
      assign node[k] = node[2*k+1] ^ node[2*k+2];
    end
  endgenerate

  assign par_o = node[0];
endmodule

// File: rtl/dap_encoder.sv
module dap_encoder #(
  parameter int unsigned DW = 4
) (
  input  logic [DW-1:0]                     data_i,
  output logic [dap_pkg::code_width(DW)-1:0] code_o
);
  localparam int unsigned CW = dap_pkg::code_width(DW);

  logic par;

  dap_parity_tree #(.N(DW)) u_par (
    .bits_i (data_i),
    .par_o  (par)
  );

  generate
    for (genvar i = 0; i < DW; i++) begin : g_dup
      assign code_o[2*i]   = data_i[i];
      assign code_o[2*i+1] = data_i[i];
    end
  endgenerate

  assign code_o[CW-1] = par;
endmodule

// File: rtl/dap_decoder.sv
module dap_decoder #(
  parameter int unsigned DW = 4
) (
  input  logic [dap_pkg::code_width(DW)-1:0] code_i,
  output logic [DW-1:0]                     data_o
);
  localparam int unsigned CW = dap_pkg::code_width(DW);

  logic [DW-1:0] copy_lo;
  logic [DW-1:0] copy_hi;
  logic          par_lo;
  logic          mismatch;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_split
      assign copy_lo[i] = code_i[2*i];
      assign copy_hi[i] = code_i[2*i+1];
    end
  endgenerate

  dap_parity_tree #(.N(DW)) u_chk (
    .bits_i (copy_lo),
    .par_o  (par_lo)
  );

  assign mismatch = par_lo ^ code_i[CW-1];

  always_comb begin
    if (mismatch) data_o = copy_hi;
    else          data_o = copy_lo;
  end
endmodule

// File: rtl/dup_parity_codec.sv
module dup_parity_codec #(
  parameter int unsigned DW = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [DW-1:0]                      tx_data,
  output logic [dap_pkg::code_width(DW)-1:0] tx_code,
  input  logic [dap_pkg::code_width(DW)-1:0] rx_code,
  input  logic                               rx_en,
  output logic [DW-1:0]                      rx_data
);
  localparam int unsigned CW = dap_pkg::code_width(DW);

  logic [CW-1:0] enc_code;
  logic [DW-1:0] dec_data;
  logic [CW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;

  dap_encoder #(.DW(DW)) u_enc (
    .data_i (tx_data),
    .code_o (enc_code)
  );

  dap_decoder #(.DW(DW)) u_dec (
    .code_i (rx_code),
    .data_o (dec_data)
  );

  always_comb begin
    tx_d = enc_code;
    rx_d = rx_q;
    if (rx_en) rx_d = dec_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_code = tx_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/dap_codec_chk.sv
module dap_codec_chk #(
  parameter int unsigned DW = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [DW-1:0]                      tx_data,
  input logic [dap_pkg::code_width(DW)-1:0] tx_code,
  input logic [dap_pkg::code_width(DW)-1:0] rx_code,
  input logic                               rx_en,
  input logic [DW-1:0]                      rx_data
);
  localparam int unsigned CW = dap_pkg::code_width(DW);

  logic [DW-1:0] lo_bits;
  logic [DW-1:0] hi_bits;
  logic          rx_clean;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      lo_bits[i] = rx_code[2*i];
      hi_bits[i] = rx_code[2*i+1];
    end
    rx_clean = (lo_bits == hi_bits) && ((^lo_bits) == rx_code[CW-1]);
  end

  // R1: both wires of every pair agree on the link output
  generate
    for (genvar i = 0; i < DW; i++) begin : g_pair
      a_r1_pair_dup: assert property (@(posedge clk) disable iff (!rst_n)
        tx_code[2*i] == tx_code[2*i+1]);
    end
  endgenerate

  // R2, R3: parity wire carries the XOR of the word seen one edge earlier
  a_r2_parity_msb: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_code[CW-1] == ^$past(tx_data));

  // R4, R9: clean codeword decodes to its data one edge later
  a_r4_clean_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_clean) |=> rx_data == $past(lo_bits));

  // R7: output frozen while the decoder is disabled
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rx_data));

  // R8: registers cleared while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_zero: assert (tx_code == '0 && rx_data == '0);
    end
  end
endmodule

bind dup_parity_codec dap_codec_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_data (tx_data),
  .tx_code (tx_code),
  .rx_code (rx_code),
  .rx_en   (rx_en),
  .rx_data (rx_data)
);

// File: tb/sim_dup_parity_codec.sv
`timescale 1ns/1ps
module sim_dup_parity_codec;
  localparam int DW = 4;
  localparam int CW = 2 * DW + 1;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] tx_data;
  logic [CW-1:0] tx_code;
  logic [CW-1:0] rx_code;
  logic          rx_en;
  logic [DW-1:0] rx_data;

  int total;
  int bad;
  int cyc;
  bit done;

  dup_parity_codec #(.DW(DW)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_data (tx_data),
    .tx_code (tx_code),
    .rx_code (rx_code),
    .rx_en   (rx_en),
    .rx_data (rx_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural model of the codeword built from the requirement text
  function automatic logic [CW-1:0] model_enc(input int d);
    logic [CW-1:0] c;
    int ones;
    c = '0;
    ones = 0;
    for (int i = 0; i < DW; i++) begin
      if ((d >> i) & 1) begin
        c[2*i]   = 1'b1;
        c[2*i+1] = 1'b1;
        ones++;
      end
    end
    c[CW-1] = (ones % 2) == 1;
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; cyc = 0; done = 0;
    rst_n = 1'b0; tx_data = '0; rx_code = '1; rx_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 tx_code in reset", 32'(tx_code), 32'd0);
    chk("R8 rx_data in reset", 32'(rx_data), 32'd0);
    rst_n = 1'b1;

    // exhaustive sweep: every word with no fault and each single fault
    for (int d = 0; d < (1 << DW); d++) begin
      for (int pos = 0; pos <= CW; pos++) begin
        logic [CW-1:0] cw;
        logic [DW-1:0] prev_rx;
        logic [CW-1:0] prev_tx;
        cw = model_enc(d);
        if (pos < CW) cw[pos] = ~cw[pos];
        prev_rx = rx_data;
        prev_tx = tx_code;
        tx_data = DW'(d);
        rx_code = cw;
        rx_en   = 1'b1;
        #1;
        chk("R3 tx_code waits for edge", 32'(tx_code), 32'(prev_tx));
        chk("R9 rx_data waits for edge", 32'(rx_data), 32'(prev_rx));
        @(negedge clk);
        chk("R1 codeword layout", 32'(tx_code), 32'(model_enc(d)));
        chk("R2 parity wire", 32'(tx_code[CW-1]), 32'(model_enc(d) >> (CW-1)));
        if (pos == CW)          chk("R4 clean decode", 32'(rx_data), 32'(d));
        else if (pos == CW - 1) chk("R6 parity wire fault", 32'(rx_data), 32'(d));
        else                    chk("R5 data wire fault", 32'(rx_data), 32'(d));
      end
    end

    // hold while disabled: load a word, then present a different one
    for (int d = 0; d < (1 << DW); d += 5) begin
      int other;
      other = (~d) & ((1 << DW) - 1);
      rx_en = 1'b1; rx_code = model_enc(d);
      @(negedge clk);
      rx_en = 1'b0; rx_code = model_enc(other);
      @(negedge clk);
      chk("R7 hold while disabled", 32'(rx_data), 32'(d));
      @(negedge clk);
      chk("R7 hold second cycle", 32'(rx_data), 32'(d));
      rx_en = 1'b1;
      @(negedge clk);
      chk("R9 reload after enable", 32'(rx_data), 32'(other));
    end

    // reset again mid-run
    tx_data = '1; rx_code = model_enc((1 << DW) - 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear tx_code", 32'(tx_code), 32'd0);
    chk("R8 async clear rx_data", 32'(rx_data), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule